// File: doc/BRIEF.md
# Ping-pong capture buffer controller

This block takes a steady stream of in-phase and quadrature samples from a converter front end and writes them into an external circular word memory. The memory is treated as two equal halves. When the last word of a half is written, the block raises a one-cycle half-ready event with the index of that half. A consumer can then drain that half while capture goes on in the other half without a pause. The consumer hands a half back by acknowledging it. If capture wraps into a half that is still held by the consumer, a sticky overrun flag is set and the old contents are overwritten, so the input rate is never throttled.

Each stored word carries one I/Q pair. In wide mode, both 16-bit values fill the word. In narrow mode, two 14-bit values sit inside fixed fields and the spare bits are zero. The buffer length and the packing mode are sampled when a run starts and do not change until the run ends. A start with an illegal length is refused and flagged.

Top module: `pingpong_capture`

## Requirements
- R1: A start while idle with `buf_len` odd, below 2, or above 2^ADDR_W (256 by default) is refused: `busy` stays low, `cfg_err` goes high, and no writes follow. An accepted start clears `cfg_err`.
- R2: A run writes its first word at address 0. Each accepted sample takes the next address, and after address `buf_len`-1 the next address is 0.
- R3: A sample presented with `smp_valid` while `busy` is high appears on the write port (`mem_we` high) exactly one clock later. Each accepted sample gives exactly one write.
- R4: With wide mode latched (`mode_16`=1 at start), the written word is Q in bits 31:16 and I in bits 15:0.
- R5: With narrow mode latched (`mode_16`=0), Q[13:0] is at bits 31:18 and I[13:0] is at bits 15:2. Bits 17:16 and 1:0 are zero.
- R6: `half_rdy` pulses together with the write of the last word of a half. `half_idx` is 0 for address `buf_len`/2-1 and 1 for address `buf_len`-1. Completing half h sets `half_pend[h]`.
- R7: Writing the first word of half h while `half_pend[h]` is set raises `overrun`. The flag stays high until the next accepted start or reset, and writing carries on into that half.
- R8: A cycle with `drain_ack` high and `ack_half`=h clears `half_pend[h]`. A half acknowledged before it is re-entered causes no overrun.
- R9: While `busy`, a new start is ignored, and changes to `buf_len` or `mode_16` do not alter addressing or packing.
- R10: `stop` ends the run. A sample valid in the same cycle as `stop` is still written. After that, `busy` is low and no further writes occur.
- R11: Reset, and likewise an accepted start, clears `overrun` and `half_pend`. Reset also clears `busy`, `cfg_err` and the write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_i | input | 16 | In-phase sample |
| smp_q | input | 16 | Quadrature sample |
| mode_16 | input | 1 | 1 = wide packing, 0 = narrow packing, sampled at start |
| buf_len | input | 9 | Total buffer length in words, sampled at start |
| start | input | 1 | Begin a run (ignored while busy) |
| stop | input | 1 | End the run after the current word |
| drain_ack | input | 1 | Consumer hands a half back |
| ack_half | input | 1 | Index of the half being acknowledged |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 8 | Memory write address |
| mem_wdata | output | 32 | Packed I/Q word |
| half_rdy | output | 1 | One-cycle event: a half was just completed |
| half_idx | output | 1 | Index of the completed half |
| half_pend | output | 2 | Per half: completed and not yet acknowledged |
| busy | output | 1 | Run in progress |
| overrun | output | 1 | Sticky: a pending half was re-entered |
| cfg_err | output | 1 | Last start was refused for its length |

## Verification
The hardest state to reach is the overrun. The consumer must hold a half across a full lap of the buffer, and the flag must then stay set while writes keep landing in the stale half. The stimulus starts a six-word narrow run and withholds acknowledgements until capture wraps into half 0 and later into half 1. It then confirms that the flag survives and that addressing continues. A separate two-word run drives every write to complete a half, which exercises back-to-back half-ready events with alternating indices.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;

    function automatic int pad_bits(int sample_w, int narrow_w);
        return sample_w - narrow_w;
    endfunction
endpackage

// File: rtl/pp_pack.sv
module pp_pack #(
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 14
) (
    input  logic                  wide,
    input  logic [SAMPLE_W-1:0]   si,
    input  logic [SAMPLE_W-1:0]   sq,
    output logic [2*SAMPLE_W-1:0] word
);
    localparam int PAD = pp_pkg::pad_bits(SAMPLE_W, NARROW_W);

    generate
        if (PAD > 0) begin : g_pad
            logic [2*SAMPLE_W-1:0] narrow;
            // narrow fields sit above PAD zero bits in each half-word
            assign narrow = {sq[NARROW_W-1:0], {PAD{1'b0}}, si[NARROW_W-1:0], {PAD{1'b0}}};
            assign word   = wide ? {sq, si} : narrow;
        end else begin : g_nopad
            logic unused_wide;
            assign unused_wide = wide;
            assign word        = {sq, si};
        end
    endgenerate
endmodule

// File: rtl/pp_len_check.sv
module pp_len_check #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic [LEN_W-1:0] len,
    output logic             ok
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1) << ADDR_W;

    always_comb begin
        ok = !len[0] && (len >= LEN_W'(2)) && (len <= MAX_LEN);
    end
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture #(
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 14,
    parameter int ADDR_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic [SAMPLE_W-1:0]   smp_i,
    input  logic [SAMPLE_W-1:0]   smp_q,
    input  logic                  mode_16,
    input  logic [ADDR_W:0]       buf_len,
    input  logic                  start,
    input  logic                  stop,
    input  logic                  drain_ack,
    input  logic                  ack_half,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [2*SAMPLE_W-1:0] mem_wdata,
    output logic                  half_rdy,
    output logic                  half_idx,
    output logic [1:0]            half_pend,
    output logic                  busy,
    output logic                  overrun,
    output logic                  cfg_err
);
    localparam int LEN_W  = ADDR_W + 1;
    localparam int WORD_W = 2 * SAMPLE_W;

    typedef struct packed {
        logic               run;
        logic               wide;
        logic [LEN_W-1:0]   len;
        logic [ADDR_W-1:0]  wptr;
        logic [1:0]         pend;
        logic               ovr;
        logic               cfg_err;
        logic               we;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  data;
        logic               hrdy;
        pp_pkg::half_e      hidx;
    } st_t;

    st_t st_d, st_q;

    logic              len_ok;
    logic [WORD_W-1:0] packed_word;
    logic [LEN_W-1:0]  half_len;
    logic [LEN_W-1:0]  wptr_x;
    logic              cur_half;

    pp_len_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_len (
        .len (buf_len),
        .ok  (len_ok)
    );

    pp_pack #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_pack (
        .wide (st_q.wide),
        .si   (smp_i),
        .sq   (smp_q),
        .word (packed_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.we   = 1'b0;
        st_d.hrdy = 1'b0;
        half_len  = st_q.len >> 1;
        wptr_x    = {1'b0, st_q.wptr};
        cur_half  = (wptr_x >= half_len);

        // consumer hand-back first, so a same-cycle ack counts before the overrun test
        if (drain_ack) begin
            st_d.pend[ack_half] = 1'b0;
        end

        if (!st_q.run) begin
            if (start) begin
                if (len_ok) begin
                    st_d.run     = 1'b1;
                    st_d.len     = buf_len;
                    st_d.wide    = mode_16;
                    st_d.wptr    = '0;
                    st_d.pend    = 2'b00;
                    st_d.ovr     = 1'b0;
                    st_d.cfg_err = 1'b0;
                end else begin
                    st_d.cfg_err = 1'b1;
                end
            end
        end else begin
            if (smp_valid) begin
                st_d.we   = 1'b1;
                st_d.addr = st_q.wptr;
                st_d.data = packed_word;
                // entering a half that the consumer still owns
                if ((wptr_x == '0) || (wptr_x == half_len)) begin
                    if (st_d.pend[cur_half]) begin
                        st_d.ovr = 1'b1;
                    end
                end
                if (wptr_x == half_len - LEN_W'(1)) begin
                    st_d.hrdy    = 1'b1;
                    st_d.hidx    = pp_pkg::HALF_LO;
                    st_d.pend[0] = 1'b1;
                end
                if (wptr_x == st_q.len - LEN_W'(1)) begin
                    st_d.hrdy    = 1'b1;
                    st_d.hidx    = pp_pkg::HALF_HI;
                    st_d.pend[1] = 1'b1;
                    st_d.wptr    = '0;
                end else begin
                    st_d.wptr = st_q.wptr + ADDR_W'(1);
                end
            end
            if (stop) begin
                st_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.data;
    assign half_rdy  = st_q.hrdy;
    assign half_idx  = st_q.hidx;
    assign half_pend = st_q.pend;
    assign busy      = st_q.run;
    assign overrun   = st_q.ovr;
    assign cfg_err   = st_q.cfg_err;
endmodule

// File: rtl/pingpong_capture_chk.sv
module pingpong_capture_chk #(
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 14,
    parameter int ADDR_W   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  mem_we,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [2*SAMPLE_W-1:0] mem_wdata,
    input logic                  half_rdy,
    input logic                  overrun,
    input logic                  cfg_err,
    input logic                  wide_q
);
    localparam int PAD = SAMPLE_W - NARROW_W;

    // R6: a half-ready event only accompanies a write
    p_rdy_with_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        half_rdy |-> mem_we);

    // R1: a refused start leaves the block idle
    p_cfgerr_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !busy);

    // R7: overrun holds until a start
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !start) |=> overrun);

    // R2: consecutive writes step by one or wrap to zero
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        ((mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))) || (mem_addr == '0)));

    // R10: no write once the run is over
    p_quiet_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !mem_we);

    generate
        if (PAD > 0) begin : g_pad_chk
            // R5: spare bits of narrow words are zero
            p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_we && !wide_q) |->
                ((mem_wdata[SAMPLE_W+PAD-1:SAMPLE_W] == '0) && (mem_wdata[PAD-1:0] == '0)));
        end
    endgenerate
endmodule

bind pingpong_capture pingpong_capture_chk #(
    .SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .half_rdy  (half_rdy),
    .overrun   (overrun),
    .cfg_err   (cfg_err),
    .wide_q    (st_q.wide)
);

// File: tb/pingpong_capture_tb.sv
`timescale 1ns/1ps
module pingpong_capture_tb;
    localparam int CLK_P = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid, mode_16, start, stop, drain_ack, ack_half;
    logic [15:0] smp_i, smp_q;
    logic [8:0]  buf_len;
    logic        mem_we, half_rdy, half_idx, busy, overrun, cfg_err;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [1:0]  half_pend;

    always #(CLK_P/2) clk = ~clk;

    pingpong_capture u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .mode_16(mode_16), .buf_len(buf_len), .start(start), .stop(stop),
        .drain_ack(drain_ack), .ack_half(ack_half), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .half_rdy(half_rdy), .half_idx(half_idx),
        .half_pend(half_pend), .busy(busy), .overrun(overrun), .cfg_err(cfg_err)
    );

    typedef struct {
        logic [7:0]  a;
        logic [31:0] d;
        logic        r;
        logic        h;
        logic        wide;
    } exp_t;

    exp_t sbq[$];
    exp_t e;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    bit       m_run, m_wide, m_cfg, m_ovr;
    int       m_len, m_wptr;
    bit [1:0] m_pend;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pack(bit wide, logic [15:0] i, logic [15:0] q);
        return wide ? {q, i} : {q[13:0], 2'b00, i[13:0], 2'b00};
    endfunction

    task automatic defaults();
        smp_valid = 1'b0; start = 1'b0; stop = 1'b0; drain_ack = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        defaults();
    endtask

    task automatic drive_sample(logic [15:0] i, logic [15:0] q, bit with_stop);
        exp_t x;
        int   h;
        @(negedge clk);
        defaults();
        smp_valid = 1'b1; smp_i = i; smp_q = q; stop = with_stop;
        if (m_run) begin
            h = (m_wptr >= m_len / 2) ? 1 : 0;
            if ((m_wptr == 0 || m_wptr == m_len / 2) && m_pend[h]) m_ovr = 1'b1;
            x.a = 8'(m_wptr); x.d = pack(m_wide, i, q); x.r = 1'b0; x.h = 1'b0; x.wide = m_wide;
            if (m_wptr == m_len / 2 - 1) begin x.r = 1'b1; x.h = 1'b0; m_pend[0] = 1'b1; end
            if (m_wptr == m_len - 1) begin
                x.r = 1'b1; x.h = 1'b1; m_pend[1] = 1'b1; m_wptr = 0;
            end else begin
                m_wptr++;
            end
            sbq.push_back(x);
            if (with_stop) m_run = 1'b0;
        end
    endtask

    task automatic do_start(int len, bit wide);
        @(negedge clk);
        defaults();
        buf_len = 9'(len); mode_16 = wide; start = 1'b1;
        if (!m_run) begin
            if (len >= 2 && len % 2 == 0 && len <= 256) begin
                m_run = 1'b1; m_len = len; m_wide = wide; m_wptr = 0;
                m_pend = 2'b00; m_ovr = 1'b0; m_cfg = 1'b0;
            end else begin
                m_cfg = 1'b1;
            end
        end
    endtask

    task automatic do_ack(bit h);
        @(negedge clk);
        defaults();
        drain_ack = 1'b1; ack_half = h; m_pend[h] = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        defaults();
        stop = 1'b1; m_run = 1'b0;
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // monitor: compare each write with the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                if (sbq.size() > 0) begin
                    e = sbq.pop_front();
                    check("R3", "write strobe", 32'(mem_we), 32'd1);
                    if (mem_we) begin
                        check("R2", "address", 32'(mem_addr), 32'(e.a));
                        check(e.wide ? "R4" : "R5", "data", mem_wdata, e.d);
                        check("R6", "half ready", 32'(half_rdy), 32'(e.r));
                        if (e.r) check("R6", "half index", 32'(half_idx), 32'(e.h));
                    end
                end else if (mem_we || half_rdy) begin
                    check("R10", "stray write", 32'(mem_we), 32'd0);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        defaults();
        smp_i = '0; smp_q = '0; mode_16 = 1'b1; buf_len = 9'd8; ack_half = 1'b0;
        m_run = 0; m_wide = 1; m_cfg = 0; m_ovr = 0; m_len = 8; m_wptr = 0; m_pend = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "busy after reset", 32'(busy), 32'd0);
        check("R11", "write after reset", 32'(mem_we), 32'd0);
        check("R11", "overrun after reset", 32'(overrun), 32'd0);
        check("R11", "pending after reset", 32'(half_pend), 32'd0);
        check("R11", "cfg_err after reset", 32'(cfg_err), 32'd0);
        rst_n = 1'b1;

        // R1: illegal lengths refused
        do_start(5, 1); idle();
        check("R1", "cfg_err odd length", 32'(cfg_err), 32'd1);
        check("R1", "busy odd length", 32'(busy), 32'd0);
        drive_sample(16'h0BAD, 16'h0BAD, 0); idle(); idle();
        do_start(0, 1); idle();
        check("R1", "busy zero length", 32'(busy), 32'd0);
        do_start(258, 1); idle();
        check("R1", "busy oversize length", 32'(busy), 32'd0);
        check("R1", "cfg_err oversize", 32'(cfg_err), 32'd1);

        // R2 R4 R6 R8: wide run of 8 words
        do_start(8, 1); idle();
        check("R1", "busy after good start", 32'(busy), 32'd1);
        check("R1", "cfg_err cleared", 32'(cfg_err), 32'd0);
        for (int k = 0; k < 4; k++) drive_sample(16'h1100 + 16'(k), 16'h2200 + 16'(k), 0);
        idle();
        check("R6", "pending after half 0", 32'(half_pend), 32'd1);
        do_ack(0); idle();
        check("R8", "pending after ack 0", 32'(half_pend), 32'd0);
        for (int k = 0; k < 4; k++) begin
            drive_sample(16'h3300 + 16'(k), 16'hC400 - 16'(k), 0);
            idle();
        end
        check("R6", "pending after half 1", 32'(half_pend), 32'd2);
        do_ack(1); idle();

        // R9: start and new settings ignored while busy
        do_start(4, 0); idle();
        check("R9", "busy kept", 32'(busy), 32'd1);
        check("R9", "cfg_err unchanged", 32'(cfg_err), 32'd0);
        for (int k = 0; k < 8; k++) begin
            drive_sample(16'h5A00 + 16'(k), 16'hFFF0 + 16'(k), 0);
            if (k == 3) do_ack(0);
            if (k == 7) do_ack(1);
        end
        idle();
        check("R8", "no overrun with timely acks", 32'(overrun), 32'd0);

        // R10: stop together with a sample
        drive_sample(16'h7777, 16'h8888, 1); idle();
        check("R10", "busy after stop", 32'(busy), 32'd0);
        drive_sample(16'h0DEA, 16'h0DEA, 0);
        drive_sample(16'h0DEB, 16'h0DEB, 0); idle(); idle();

        // R5 R7: narrow run, consumer never acknowledges
        do_start(6, 0); idle();
        drive_sample(16'hFFFF, 16'hFFFF, 0);
        drive_sample(16'hABCD, 16'h1234, 0);
        for (int k = 0; k < 4; k++) drive_sample(16'h8001 + 16'(k), 16'h7FFE - 16'(k), 0);
        idle();
        check("R7", "no overrun before wrap", 32'(overrun), 32'd0);
        drive_sample(16'hC0DE, 16'hBEEF, 0); idle();
        check("R7", "overrun on wrap", 32'(overrun), 32'd1);
        for (int k = 0; k < 3; k++) drive_sample(16'h0101 * 16'(k + 1), 16'h1010 * 16'(k + 1), 0);
        idle();
        check("R7", "overrun sticky", 32'(overrun), 32'd1);
        check("R7", "still busy", 32'(busy), 32'd1);
        do_stop(); idle();

        // R11 start clears flags; R6 with one-word halves
        do_start(2, 1); idle();
        check("R11", "overrun cleared by start", 32'(overrun), 32'd0);
        check("R11", "pending cleared by start", 32'(half_pend), 32'd0);
        drive_sample(16'h0001, 16'h0002, 0);
        drive_sample(16'h0003, 16'h0004, 0);
        idle();
        check("R6", "both halves pending", 32'(half_pend), 32'd3);
        do_ack(0); do_ack(1);
        drive_sample(16'h0005, 16'h0006, 0);
        drive_sample(16'h0007, 16'h0008, 0);
        idle();
        check("R8", "no overrun two-word run", 32'(overrun), 32'd0);

        // R11: reset in the middle of a run
        @(negedge clk); rst_n = 1'b0;
        m_run = 0; m_pend = 0; m_ovr = 0; m_cfg = 0;
        @(negedge clk);
        check("R11", "busy after mid-run reset", 32'(busy), 32'd0);
        check("R11", "pending after mid-run reset", 32'(half_pend), 32'd0);
        check("R11", "write port after mid-run reset", 32'(mem_we), 32'd0);
        rst_n = 1'b1;
        idle(); idle();

        check("R3", "scoreboard drained", 32'(sbq.size()), 32'd0);
        done = 1'b1;
        report();
        $finish;
    end
endmodule